// File: doc/BRIEF.md
# Vectored Interrupt Controller with Power-Down Release

This block collects a set of interrupt sources. Each source has a pending flag and an enable bit. The block combines them with a global master enable, a two-bit service level that controls nesting, and a per-source high-priority mask, and from these it decides when to launch a vectored service. When it accepts a request, it raises a one-cycle take strobe towards the CPU together with the index of the winning source. In the same cycle it clears that source's pending flag and raises the service level. A return pulse from the CPU restores the level that was active before the most recent take.

The block also drives a power-down release output. This output follows only the pending flags and the per-source enables, so an enabled pending source wakes a sleeping core even while the master enable is off. In that case no service is launched. Source 0 never contributes to the release output.

Software reaches the block through a small write-only register port with six addresses:
- address 0 sets pending flags (write one to set);
- address 1 clears pending flags (write one to clear);
- address 2 holds the enable bits;
- address 3 holds the high-priority mask;
- address 4 bit 0 is the master enable;
- address 5 bits [1:0] set the service level directly.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one on `hw_req_i[k]` sets pending flag k, and the flag is visible on `req_pend_o[k]` after the next rising clock edge.
- R2: Writing address 0 sets every pending flag whose data bit is one. The flag then behaves exactly like a hardware request, including being serviced.
- R3: Writing address 1 clears every pending flag whose data bit is one. A hardware request or a software set for the same source in the same cycle wins, so the flag stays set.
- R4: A pending flag stays set until it is serviced or cleared by software, however long it is blocked.
- R5: A service starts only when the flag, its enable bit (address 2) and the master enable (address 4 bit 0) are all one and the level permits it. `take_o` then rises one clock edge after these conditions first hold.
- R6: When several sources are eligible in the same cycle, the lowest-numbered one is serviced first.
- R7: At level 0 any eligible source is accepted. At level 1 only sources whose bit is set in the priority mask (address 3) are accepted. At levels 2 and 3 nothing is accepted. Address 5 writes the level directly.
- R8: On a take, `take_o` is high for exactly one cycle and `vec_o` holds the source index. In the same cycle the source's flag clears and the level becomes 2 for a high-priority source, or 1 otherwise.
- R9: A pulse on `iret_i` restores the level that was active before the most recent take that has not yet been returned. No take starts in a cycle that carries a return or a level write.
- R10: `wake_o` is high whenever some source numbered 1 or above has both its flag and its enable bit set, regardless of the master enable. Source 0 never drives it.
- R11: While `rst_n` is low at a clock edge, all flags, enables, the priority mask, the master enable, the saved levels and the level return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req_i | input | NUM_SRC | Hardware request, one bit per source |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address (0 set, 1 clear, 2 enable, 3 priority, 4 control, 5 level) |
| cfg_wdata_i | input | NUM_SRC | Register write data |
| iret_i | input | 1 | Return-from-service pulse |
| take_o | output | 1 | One-cycle strobe: a vectored service is launched |
| vec_o | output | $clog2(NUM_SRC) | Index of the serviced source |
| wake_o | output | 1 | Power-down release request |
| req_pend_o | output | NUM_SRC | Current pending flags |
| level_o | output | 2 | Current service level |

## Verification
Assertions check the following on every cycle:
- pending flags persist and hardware or software sets win;
- a take needs a master enable and an open level one cycle earlier;
- the lowest eligible index is picked;
- a serviced flag clears and the level rises;
- a return restores the saved level;
- source 0 alone never wakes the device.

Only the directed scenarios can show the exact take latency and the orderings across several takes and returns. They also confirm that the wake output works with the master enable off. These orderings include a low-priority service pre-empted by a high-priority one, and a blocked request being released once the level unwinds.

// File: rtl/irqv_pkg.sv
// Package: irqv_pkg
// Shared register addresses and the service-level encoding of the
// vectored interrupt controller. Assumes a 3-bit register address.
package irqv_pkg;

    localparam logic [2:0] ADDR_SET  = 3'd0;
    localparam logic [2:0] ADDR_CLR  = 3'd1;
    localparam logic [2:0] ADDR_EN   = 3'd2;
    localparam logic [2:0] ADDR_PRIO = 3'd3;
    localparam logic [2:0] ADDR_CTRL = 3'd4;
    localparam logic [2:0] ADDR_LVL  = 3'd5;

    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_MASK = 2'd3
    } lvl_t;

endpackage

// File: rtl/irqv_req_bank.sv
// Module: irqv_req_bank
// Holds one pending flag per source. Hardware and software sets win over
// software clears and over the clear caused by a take in the same cycle.
// Assumes take_clr_i carries at most one bit.
module irqv_req_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req_i,
    input  logic [NUM_SRC-1:0] sw_set_i,
    input  logic [NUM_SRC-1:0] sw_clr_i,
    input  logic [NUM_SRC-1:0] take_clr_i,
    output logic [NUM_SRC-1:0] flag_o
);

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] set_all;

    // Merge both set sources into one vector.
    always_comb begin
        set_all = hw_req_i | sw_set_i;
    end

    // Update the pending flags: set wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~sw_clr_i & ~take_clr_i) | set_all;
        end
    end

    assign flag_o = flag_q;

    // R1 / R2 / R3: every set request is visible one edge later.
    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_q & $past(set_all)) == $past(set_all)));

    // R4: a flag that is neither cleared nor taken stays set.
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_q & $past(flag_q & ~sw_clr_i & ~take_clr_i))
                         == $past(flag_q & ~sw_clr_i & ~take_clr_i)));

endmodule

// File: rtl/irqv_pick.sv
// Module: irqv_pick
// Fixed-priority selector: reports whether any eligible bit is set and
// the index of the lowest-numbered one. Purely combinational.
module irqv_pick #(
    parameter int NUM_SRC = 8,
    localparam int IW = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] elig_i,
    output logic               grant_v_o,
    output logic [IW-1:0]      grant_idx_o
);

    // Scan from the top down so the lowest set bit is the last assignment.
    always_comb begin
        grant_v_o   = 1'b0;
        grant_idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                grant_v_o   = 1'b1;
                grant_idx_o = IW'(i);
            end
        end
    end

    // R6: no eligible bit lies below the granted index.
    always_comb begin
        if (grant_v_o) begin
            a_r6_lowest_wins: assert ((elig_i & ((NUM_SRC'(1) << grant_idx_o) - NUM_SRC'(1))) == '0);
        end
    end

endmodule

// File: rtl/irqv_level.sv
// Module: irqv_level
// Tracks the service level and a small stack of the levels that were
// active before each outstanding take. Priority among the inputs:
// level write, then return, then take. Assumes NEST_DEPTH >= 2; a push
// beyond NEST_DEPTH is dropped.
module irqv_level
    import irqv_pkg::*;
#(
    parameter int NEST_DEPTH = 2,
    localparam int SW = 2 * NEST_DEPTH,
    localparam int DW = $clog2(NEST_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic take_hi_i,
    input  logic ret_i,
    input  logic wr_i,
    input  lvl_t wr_lvl_i,
    output lvl_t level_o
);

    lvl_t          level_q;
    logic [SW-1:0] stk_q;
    logic [DW-1:0] depth_q;

    // Level and stack update: write, pop on return, push on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_IDLE;
            stk_q   <= '0;
            depth_q <= '0;
        end else if (wr_i) begin
            level_q <= wr_lvl_i;
        end else if (ret_i) begin
            if (depth_q != '0) begin
                level_q <= lvl_t'(stk_q[1:0]);
                stk_q   <= stk_q >> 2;
                depth_q <= depth_q - 1'b1;
            end
        end else if (take_i) begin
            level_q <= take_hi_i ? LVL_HIGH : LVL_LOW;
            if (depth_q != DW'(NEST_DEPTH)) begin
                stk_q   <= {stk_q[SW-3:0], level_q};
                depth_q <= depth_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    // R9: a return with a saved entry restores the top of the stack.
    a_r9_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !wr_i && depth_q != '0) |=> (level_q == lvl_t'($past(stk_q[1:0]))));

    // R8: a take always leaves a non-idle level.
    a_r8_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !ret_i && !wr_i) |=> (level_q != LVL_IDLE));

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: irq_vector_ctrl
// Top of the vectored interrupt controller. Holds the configuration
// registers, forms the per-source eligibility, registers the take strobe
// and vector, and drives the power-down release output. Assumes
// NUM_SRC is between 4 and 32 and that writes and returns are single-cycle.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int NEST_DEPTH = 2,
    localparam int IW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req_i,
    input  logic               cfg_wr_i,
    input  logic [2:0]         cfg_addr_i,
    input  logic [NUM_SRC-1:0] cfg_wdata_i,
    input  logic               iret_i,
    output logic               take_o,
    output logic [IW-1:0]      vec_o,
    output logic               wake_o,
    output logic [NUM_SRC-1:0] req_pend_o,
    output logic [1:0]         level_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] prio_q;
    logic               ime_q;
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] sw_set;
    logic [NUM_SRC-1:0] sw_clr;
    logic [NUM_SRC-1:0] take_clr;
    logic [NUM_SRC-1:0] elig;
    logic               lvl_wr;
    logic               grant_v;
    logic [IW-1:0]      grant_idx;
    logic               fire;
    logic               take_q;
    logic [IW-1:0]      vec_q;
    lvl_t               level_w;

    // Decode the register write port into set, clear and level strobes.
    always_comb begin
        sw_set = (cfg_wr_i && cfg_addr_i == ADDR_SET) ? cfg_wdata_i : '0;
        sw_clr = (cfg_wr_i && cfg_addr_i == ADDR_CLR) ? cfg_wdata_i : '0;
        lvl_wr = cfg_wr_i && (cfg_addr_i == ADDR_LVL);
    end

    // Configuration registers: enables, priority mask, master enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
            ime_q  <= 1'b0;
        end else if (cfg_wr_i) begin
            case (cfg_addr_i)
                ADDR_EN:   en_q   <= cfg_wdata_i;
                ADDR_PRIO: prio_q <= cfg_wdata_i;
                ADDR_CTRL: ime_q  <= cfg_wdata_i[0];
                default:   ;
            endcase
        end
    end

    irqv_req_bank #(
        .NUM_SRC(NUM_SRC)
    ) req_bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_req_i  (hw_req_i),
        .sw_set_i  (sw_set),
        .sw_clr_i  (sw_clr),
        .take_clr_i(take_clr),
        .flag_o    (req_q)
    );

    // Per-source eligibility from flag, enable, master enable and level.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            elig[i] = req_q[i] && en_q[i] && ime_q &&
                      ((level_w == LVL_IDLE) || (level_w == LVL_LOW && prio_q[i]));
        end
    end

    irqv_pick #(
        .NUM_SRC(NUM_SRC)
    ) pick_i (
        .elig_i     (elig),
        .grant_v_o  (grant_v),
        .grant_idx_o(grant_idx)
    );

    // A take is suppressed in cycles that return or rewrite the level.
    always_comb begin
        fire     = grant_v && !iret_i && !lvl_wr;
        take_clr = fire ? (NUM_SRC'(1) << grant_idx) : '0;
    end

    irqv_level #(
        .NEST_DEPTH(NEST_DEPTH)
    ) level_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (fire),
        .take_hi_i(prio_q[grant_idx]),
        .ret_i    (iret_i),
        .wr_i     (lvl_wr),
        .wr_lvl_i (lvl_t'(cfg_wdata_i[1:0])),
        .level_o  (level_w)
    );

    // Register the take strobe and the vector for the CPU side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= fire;
            if (fire) begin
                vec_q <= grant_idx;
            end
        end
    end

    assign take_o     = take_q;
    assign vec_o      = vec_q;
    assign wake_o     = |(req_q[NUM_SRC-1:1] & en_q[NUM_SRC-1:1]);
    assign req_pend_o = req_q;
    assign level_o    = level_w;

    // R5: a take follows a cycle with the master enable on.
    a_r5_take_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> $past(ime_q));

    // R7: a take only starts from level 0 or 1.
    a_r7_level_open: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> (($past(level_w) == LVL_IDLE) || ($past(level_w) == LVL_LOW)));

    // R8: the serviced flag is clear unless it was set again at the take edge.
    a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (take_q && ((($past(hw_req_i | sw_set)) >> vec_q) & NUM_SRC'(1)) == '0)
        |-> (((req_q >> vec_q) & NUM_SRC'(1)) == '0));

    // R10: source 0 alone never wakes the device.
    a_r10_src0_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & en_q) == NUM_SRC'(1)) |-> !wake_o);

endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
// Directed bench for irq_vector_ctrl: one task per scenario.
module irq_vector_ctrl_tb_top;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  hw_req_i;
    logic          cfg_wr_i;
    logic [2:0]    cfg_addr_i;
    logic [N-1:0]  cfg_wdata_i;
    logic          iret_i;
    logic          take_o;
    logic [IW-1:0] vec_o;
    logic          wake_o;
    logic [N-1:0]  req_pend_o;
    logic [1:0]    level_o;

    int checks = 0;
    int errors = 0;

    irq_vector_ctrl #(.NUM_SRC(N), .NEST_DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req_i), .cfg_wr_i(cfg_wr_i),
        .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .iret_i(iret_i),
        .take_o(take_o), .vec_o(vec_o), .wake_o(wake_o),
        .req_pend_o(req_pend_o), .level_o(level_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        tick();
        cfg_wr_i = 1'b0;
    endtask

    task automatic ret_pulse();
        iret_i = 1'b1;
        tick();
        iret_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hw_req_i = '0; cfg_wr_i = 1'b0; cfg_addr_i = '0;
        cfg_wdata_i = '0; iret_i = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R11 pend", int'(req_pend_o), 0);
        chk("R11 level", int'(level_o), 0);
        chk("R11 take", int'(take_o), 0);
        chk("R11 wake", int'(wake_o), 0);
    endtask

    task automatic t_hw_take();
        do_reset();
        wr(3'd2, 8'h04); wr(3'd4, 8'h01);
        hw_req_i = 8'h04; tick(); hw_req_i = '0;
        chk("R1 flag set", int'(req_pend_o[2]), 1);
        chk("R5 no take yet", int'(take_o), 0);
        tick();
        chk("R8 take", int'(take_o), 1);
        chk("R8 vec", int'(vec_o), 2);
        chk("R8 flag cleared", int'(req_pend_o[2]), 0);
        chk("R8 level low", int'(level_o), 1);
        tick();
        chk("R8 one-cycle strobe", int'(take_o), 0);
        ret_pulse();
        chk("R9 level back", int'(level_o), 0);
    endtask

    task automatic t_sw_set();
        do_reset();
        wr(3'd2, 8'h10); wr(3'd4, 8'h01);
        wr(3'd0, 8'h10);
        chk("R2 sw set", int'(req_pend_o[4]), 1);
        tick();
        chk("R2 sw take", int'(take_o), 1);
        chk("R2 sw vec", int'(vec_o), 4);
    endtask

    task automatic t_clear_race();
        do_reset();
        wr(3'd0, 8'h40);
        chk("R3 set", int'(req_pend_o[6]), 1);
        hw_req_i = 8'h40;
        wr(3'd1, 8'h40);
        hw_req_i = '0;
        chk("R3 set beats clear", int'(req_pend_o[6]), 1);
        wr(3'd1, 8'h40);
        chk("R3 clear", int'(req_pend_o[6]), 0);
    endtask

    task automatic t_persist();
        do_reset();
        wr(3'd0, 8'h08);
        for (int i = 0; i < 5; i++) tick();
        chk("R4 flag kept", int'(req_pend_o[3]), 1);
        chk("R5 no enable no take", int'(take_o), 0);
        wr(3'd2, 8'h08); tick();
        chk("R5 master off no take", int'(take_o), 0);
        chk("R4 flag still kept", int'(req_pend_o[3]), 1);
        wr(3'd4, 8'h01);
        chk("R5 not before edge", int'(take_o), 0);
        tick();
        chk("R5 take", int'(take_o), 1);
        chk("R5 vec", int'(vec_o), 3);
    endtask

    task automatic t_lowest();
        do_reset();
        wr(3'd2, 8'hFF); wr(3'd0, 8'h28); wr(3'd4, 8'h01);
        tick();
        chk("R6 lowest take", int'(take_o), 1);
        chk("R6 lowest vec", int'(vec_o), 3);
        tick();
        chk("R7 level1 blocks low", int'(take_o), 0);
        chk("R7 src5 pending", int'(req_pend_o[5]), 1);
        ret_pulse();
        chk("R9 no take on return", int'(take_o), 0);
        tick();
        chk("R6 next take", int'(take_o), 1);
        chk("R6 next vec", int'(vec_o), 5);
    endtask

    task automatic t_nesting();
        do_reset();
        wr(3'd2, 8'hFF); wr(3'd3, 8'h02); wr(3'd4, 8'h01);
        wr(3'd0, 8'h10); tick();
        chk("R8 outer vec", int'(vec_o), 4);
        chk("R8 outer level", int'(level_o), 1);
        wr(3'd0, 8'h02); tick();
        chk("R7 high preempts", int'(take_o), 1);
        chk("R7 high vec", int'(vec_o), 1);
        chk("R8 level high", int'(level_o), 2);
        wr(3'd0, 8'h04); tick();
        chk("R7 level2 blocks", int'(take_o), 0);
        ret_pulse();
        chk("R9 pop to 1", int'(level_o), 1);
        tick();
        chk("R7 low still blocked", int'(take_o), 0);
        ret_pulse();
        chk("R9 pop to 0", int'(level_o), 0);
        tick();
        chk("R9 released take", int'(take_o), 1);
        chk("R9 released vec", int'(vec_o), 2);
    endtask

    task automatic t_level_write();
        do_reset();
        wr(3'd2, 8'hFF); wr(3'd4, 8'h01); wr(3'd5, 8'h03);
        wr(3'd0, 8'h01); tick();
        chk("R7 level3 blocks", int'(take_o), 0);
        chk("R7 level3 value", int'(level_o), 3);
        wr(3'd5, 8'h00);
        chk("R9 no take on level write", int'(take_o), 0);
        tick();
        chk("R7 level0 take", int'(take_o), 1);
        chk("R7 level0 vec", int'(vec_o), 0);
    endtask

    task automatic t_wake();
        do_reset();
        wr(3'd2, 8'h01); wr(3'd0, 8'h01);
        chk("R10 src0 no wake", int'(wake_o), 0);
        wr(3'd0, 8'h02);
        chk("R10 disabled no wake", int'(wake_o), 0);
        wr(3'd2, 8'h03);
        chk("R10 wake master off", int'(wake_o), 1);
        tick();
        chk("R10 no take master off", int'(take_o), 0);
        chk("R10 wake held", int'(wake_o), 1);
    endtask

    task automatic t_reset_mid();
        wr(3'd5, 8'h02);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R11 pend cleared", int'(req_pend_o), 0);
        chk("R11 level cleared", int'(level_o), 0);
        chk("R11 wake cleared", int'(wake_o), 0);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_hw_take();
                t_sw_set();
                t_clear_race();
                t_persist();
                t_lowest();
                t_nesting();
                t_level_write();
                t_wake();
                t_reset_mid();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule